// File: doc/BRIEF.md
# Hybrid-Switching Successive-Approximation Conversion Controller

This block sequences a 12-bit fully differential successive-approximation converter whose inputs are sampled onto the top plates of two capacitor arrays, P and N. Each frame is one sampling cycle followed by twelve conversion cycles, and frames run back to back. A 1 kS/s rate therefore needs a 13 kHz clock. The block reads one comparator decision per conversion cycle. It drives the sample switch, one bottom-plate control bit for every capacitor of both arrays (including a unit dummy capacitor on each side), and a registered result with a one-cycle done strobe.

Every step except the last moves the P and N arrays by equal and opposite amounts, so the common-mode level stays fixed. Each such step sets the next-lower capacitor on both sides and grounds the current capacitor on the side that compared higher. The last step grounds only the dummy on the higher side. This accepts a small common-mode shift and, in return, allows an array of half the size that a fully complementary scheme would need. The capacitor arrays, the switches and the comparator are outside the block.

Top module: `sar_hybrid_top`

## Requirements
- R1: A frame is exactly 1 sampling cycle followed by NBITS conversion cycles, with no idle cycle between frames. `sampleEn` is 1 only in the sampling cycle.
- R2: Control-bit encoding, the same on both sides: bit 0 drives the dummy (weight 1), and bit j (j ≥ 1) drives the capacitor of weight 2^(j-1). A value of 1 ties the bottom plate to supply and 0 ties it to ground. During sampling both sides hold the preset pattern, with bit NBITS-1 and bit 0 at 1 and all other bits at 0.
- R3: In conversion cycle 1 the control bits keep the preset pattern.
- R4: Entering conversion cycle x (2 ≤ x ≤ NBITS-1), bit NBITS-x is set on both sides. Bit NBITS-x+1 is cleared on the P side if the previous decision was 1 (P above N), and on the N side otherwise.
- R5: Entering the last conversion cycle, only the dummy bit (bit 0) of the side that compared higher is cleared. Every other bit on both sides keeps its value.
- R6: The comparator value sampled at the end of conversion cycle x becomes result bit NBITS-x. `cmpHigh` = 1 means P above N.
- R7: `result` and a one-cycle `done` pulse are updated at the edge that ends the last conversion cycle. `result` holds its value at all other times.
- R8: A synchronous active-high reset forces the sampling cycle and the preset pattern, and clears `result` and `done`.
- R9: The weighted sum of P plus N control bits equals twice the preset weight in conversion cycles 1 to NBITS-1. It is one unit lower in the last cycle.
- R10: With an ideal array and a scaled odd differential input d in (-2^NBITS, 2^NBITS), the result is (d + 2^NBITS - 1)/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpHigh | input | 1 | Comparator decision, 1 when P side is above N side |
| sampleEn | output | 1 | Top-plate sample switch enable |
| capCtrlP | output | NBITS | Bottom-plate controls, P array (bit 0 dummy) |
| capCtrlN | output | NBITS | Bottom-plate controls, N array (bit 0 dummy) |
| result | output | NBITS | Last completed conversion code |
| done | output | 1 | One-cycle pulse when `result` updates |

## Verification
The hardest condition to reach from the ports is the final one-sided step with each polarity, combined with a chosen path through the earlier complementary steps. Reaching it needs a comparator that responds to the block's own switching. The bench closes that loop with an ideal array model that holds a sampled differential input and turns the live control bits into a decision. Odd inputs at both range ends, around zero and in the middle force the last decision both ways. A reset applied mid-frame checks recovery into a clean sampling cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int IDX_W = 8;
  typedef logic [IDX_W-1:0] capIdx_t;

  typedef struct packed {
    logic    doSample;
    logic    converting;
    logic    inFirst;
    logic    applyMid;
    logic    applyLast;
    logic    finish;
    capIdx_t setIdx;
    capIdx_t clearIdx;
  } sarStrobes_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic        clk,
  input  logic        rst,
  output sarStrobes_t strobes
);
  localparam int PHASE_W = $clog2(NBITS + 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NBITS);
  localparam logic [PHASE_W-1:0] ONE = PHASE_W'(1);

  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (phase == LAST_PHASE) phase <= '0;
    else phase <= phase + ONE;
  end

  // Strobes describe the current cycle; the datapath acts at its ending edge.
  always_comb begin
    strobes.doSample   = (phase == '0);
    strobes.converting = (phase != '0);
    strobes.inFirst    = (phase == ONE);
    strobes.applyMid   = (phase >= ONE) && (phase <= PHASE_W'(NBITS - 2));
    strobes.applyLast  = (phase == PHASE_W'(NBITS - 1));
    strobes.finish     = (phase == LAST_PHASE);
    strobes.clearIdx   = capIdx_t'(NBITS) - capIdx_t'(phase);
    strobes.setIdx     = strobes.clearIdx - capIdx_t'(1);
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    strobes.finish |=> strobes.doSample) else $error("frame did not wrap"); // R1
  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobes.doSample |=> !strobes.doSample) else $error("sampling longer than one cycle"); // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PHASE) else $error("phase out of range"); // R1
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  sarStrobes_t       strobes,
  input  logic              cmpHigh,
  output logic [NBITS-1:0]  capP,
  output logic [NBITS-1:0]  capN,
  output logic [NBITS-1:0]  result,
  output logic              done
);
  localparam logic [NBITS-1:0] PRESET = (NBITS'(1) << (NBITS - 1)) | NBITS'(1);
  localparam int PRESET_SUM = (1 << (NBITS - 2)) + 1;

  logic [NBITS-1:0] nextP, nextN, workBits, nextWork;

  for (genvar j = 0; j < NBITS; j++) begin : g_lane
    localparam capIdx_t LANE = capIdx_t'(j);
    localparam bit IS_DUMMY = (j == 0);
    logic laneP, laneN, laneW;

    always_comb begin
      laneP = capP[j];
      laneN = capN[j];
      laneW = workBits[j];
      if (strobes.finish) begin
        laneP = PRESET[j];
        laneN = PRESET[j];
      end else if (strobes.applyMid) begin
        if (strobes.setIdx == LANE) begin
          laneP = 1'b1;
          laneN = 1'b1;
        end
        if (strobes.clearIdx == LANE) begin
          if (cmpHigh) laneP = 1'b0;
          else         laneN = 1'b0;
        end
      end else if (strobes.applyLast && IS_DUMMY) begin
        if (cmpHigh) laneP = 1'b0;
        else         laneN = 1'b0;
      end
      if (strobes.converting && strobes.clearIdx == LANE) laneW = cmpHigh;
    end

    assign nextP[j]    = laneP;
    assign nextN[j]    = laneN;
    assign nextWork[j] = laneW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capP     <= PRESET;
      capN     <= PRESET;
      workBits <= '0;
      result   <= '0;
      done     <= 1'b0;
    end else begin
      capP     <= nextP;
      capN     <= nextN;
      workBits <= nextWork;
      done     <= strobes.finish;
      if (strobes.finish) result <= nextWork;
    end
  end

  function automatic int wsum(input logic [NBITS-1:0] v);
    int s;
    s = int'(v[0]);
    for (int k = 1; k < NBITS; k++) s += int'(v[k]) << (k - 1);
    return s;
  endfunction

  AST_PRESET_HELD: assert property (@(posedge clk) disable iff (rst)
    strobes.doSample |-> (capP == PRESET && capN == PRESET)) else $error("preset missing"); // R2
  AST_FIRST_STILL: assert property (@(posedge clk) disable iff (rst)
    strobes.inFirst |-> ($stable(capP) && $stable(capN))) else $error("first cycle moved"); // R3
  AST_LAST_ONESIDED: assert property (@(posedge clk) disable iff (rst)
    strobes.finish |-> (capP[NBITS-1:1] == $past(capP[NBITS-1:1]) &&
                        capN[NBITS-1:1] == $past(capN[NBITS-1:1]) &&
                        $countones({capP[0], capN[0]}) == 1)) else $error("last step not one-sided"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done too long"); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(result)) else $error("result moved"); // R7
  AST_CM_FLAT: assert property (@(posedge clk) disable iff (rst)
    (strobes.converting && !strobes.finish) |-> (wsum(capP) + wsum(capN) == 2 * PRESET_SUM))
    else $error("common mode moved"); // R9
  AST_CM_LAST: assert property (@(posedge clk) disable iff (rst)
    strobes.finish |-> (wsum(capP) + wsum(capN) == 2 * PRESET_SUM - 1))
    else $error("last step weight wrong"); // R9
endmodule

// File: rtl/sar_hybrid_top.sv
module sar_hybrid_top
  import sar_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmpHigh,
  output logic             sampleEn,
  output logic [NBITS-1:0] capCtrlP,
  output logic [NBITS-1:0] capCtrlN,
  output logic [NBITS-1:0] result,
  output logic             done
);
  sarStrobes_t strobes;

  sar_ctrl #(.NBITS(NBITS)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  sar_datapath #(.NBITS(NBITS)) datapath_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cmpHigh (cmpHigh),
    .capP    (capCtrlP),
    .capN    (capCtrlN),
    .result  (result),
    .done    (done)
  );

  assign sampleEn = strobes.doSample;
endmodule

// File: tb/sar_hybrid_top_tb.sv
module sar_hybrid_top_tb_top;
  localparam int NB = 12;
  localparam int FULL = 1 << NB;
  localparam logic [NB-1:0] PRESET = (NB'(1) << (NB - 1)) | NB'(1);
  localparam int PSUM = (1 << (NB - 2)) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmpHigh;
  logic sampleEn, done;
  logic [NB-1:0] capCtrlP, capCtrlN, result;

  int vinDrive = 1;
  int dutHeld = 1;
  int checks = 0;
  int errors = 0;

  int refPhase = 0;
  logic [NB-1:0] refP = PRESET, refN = PRESET, refBits = '0, refResult = '0;
  logic refDone = 1'b0;
  bit refValid = 1'b0;
  bit inRst = 1'b0;
  int refHeld = 1;
  int frameVin = 1;

  always #2 clk = ~clk;

  sar_hybrid_top #(.NBITS(NB)) dut_i (
    .clk(clk), .rst(rst), .cmpHigh(cmpHigh), .sampleEn(sampleEn),
    .capCtrlP(capCtrlP), .capCtrlN(capCtrlN), .result(result), .done(done)
  );

  function automatic int wsum(input logic [NB-1:0] v);
    int s;
    s = int'(v[0]);
    for (int k = 1; k < NB; k++) s += int'(v[k]) << (k - 1);
    return s;
  endfunction

  // Ideal array: held scaled input plus two scaled units per unit of weight.
  always_comb cmpHigh = (dutHeld + 2 * (wsum(capCtrlP) - wsum(capCtrlN))) > 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: behavioural frame sequencer driven by its own array model.
  always @(posedge clk) begin
    bit dec;
    int x;
    refValid = 1'b1;
    if (rst) begin
      inRst = 1'b1;
      refPhase = 0; refP = PRESET; refN = PRESET;
      refBits = '0; refResult = '0; refDone = 1'b0;
    end else begin
      inRst = 1'b0;
      refDone = 1'b0;
      dec = (refHeld + 2 * (wsum(refP) - wsum(refN))) > 0;
      if (refPhase == 0) refPhase = 1;
      else begin
        refBits[NB - refPhase] = dec;
        if (refPhase == NB) begin
          refResult = refBits; refDone = 1'b1;
          refP = PRESET; refN = PRESET;
          frameVin = refHeld; refPhase = 0;
        end else begin
          x = refPhase + 1;
          if (x < NB) begin
            refP[NB - x] = 1'b1; refN[NB - x] = 1'b1;
            if (dec) refP[NB - x + 1] = 1'b0; else refN[NB - x + 1] = 1'b0;
          end else begin
            if (dec) refP[0] = 1'b0; else refN[0] = 1'b0;
          end
          refPhase = x;
        end
      end
    end
  end

  always @(negedge clk) begin
    string capReq;
    if (refValid) begin
      if (inRst) begin
        chk(sampleEn == 1'b1 && capCtrlP == PRESET && capCtrlN == PRESET, "R8", "reset state caps",
            int'(capCtrlP), int'(PRESET));
        chk(result == '0 && done == 1'b0, "R8", "reset result", int'(result), 0);
      end else begin
        if (refPhase == 0) capReq = "R2";
        else if (refPhase == 1) capReq = "R3";
        else if (refPhase < NB) capReq = "R4";
        else capReq = "R5";
        chk(sampleEn == (refPhase == 0), "R1", "sampleEn", int'(sampleEn), int'(refPhase == 0));
        chk(capCtrlP == refP, capReq, "capCtrlP", int'(capCtrlP), int'(refP));
        chk(capCtrlN == refN, capReq, "capCtrlN", int'(capCtrlN), int'(refN));
        chk(done == refDone, "R7", "done", int'(done), int'(refDone));
        chk(result == refResult, refDone ? "R6" : "R7", "result", int'(result), int'(refResult));
        if (refPhase >= 1 && refPhase < NB)
          chk(wsum(capCtrlP) + wsum(capCtrlN) == 2 * PSUM, "R9", "weight sum",
              wsum(capCtrlP) + wsum(capCtrlN), 2 * PSUM);
        if (refPhase == NB)
          chk(wsum(capCtrlP) + wsum(capCtrlN) == 2 * PSUM - 1, "R9", "last weight sum",
              wsum(capCtrlP) + wsum(capCtrlN), 2 * PSUM - 1);
        if (refDone)
          chk(int'(result) == (frameVin + FULL - 1) / 2, "R10", "end-to-end code",
              int'(result), (frameVin + FULL - 1) / 2);
      end
    end
    if (sampleEn) dutHeld = vinDrive;
    if (refPhase == 0) refHeld = vinDrive;
  end

  task automatic runFrame(input int v);
    do begin
      @(posedge clk); #1;
    end while (refPhase != 0);
    vinDrive = v;
    @(posedge clk); #1;
    vinDrive = -v + 2;  // changes after sampling must not reach the result
  endtask

  initial begin
    int vals[12] = '{1, -1, 4095, -4095, 2731, -1365, 2049, -2047, 7, 3, 1023, -3001};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    foreach (vals[i]) runFrame(vals[i]);
    repeat (5) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    runFrame(-5);
    runFrame(3999);
    repeat (2 * (NB + 1)) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule